// File: doc/BRIEF.md
# Parity-Protected Write-Through Data Cache

This block is a direct-mapped first-level data cache placed between a processor load/store port and a larger next-level memory. Each line holds a valid flag, an address tag and a block of data, and every data byte carries its own even-parity bit. Loads that hit a line with correct parity are answered from the cache. Loads that miss fetch the whole line from the next level, fill it and return the requested word.

Stores follow a write-through, no-write-allocate policy. A store that hits updates the cached word and regenerates its parity. Every store, whether it hits or misses, is sent on to the next level as a single word write. Because no line is ever dirty, an eviction never needs a write-back, and each processor access produces at most one next-level request.

A load that finds a parity mismatch in the addressed word is not reported as a fault. The block treats it as a miss, refetches the line, hands the fresh word to the processor and adds one to a saturating error counter. A fault-injection input lets a test corrupt the parity of the word being written, so that this path can be exercised through the ports.

Top module: `wt_l1_cache`

## Requirements
- R1: A load whose line is valid, whose tag matches and whose addressed word has good parity returns the cached word with `cpu_rsp_valid` high for one cycle, two clock edges after acceptance, and issues no next-level request.
- R2: A load that misses issues exactly one next-level read with `mem_we` low and the line-aligned address (offset bits zero). When `mem_ack` arrives it fills the line from `mem_rline` (word k in bits k*32 upward) and returns the requested word on the next cycle.
- R3: Every store issues exactly one next-level write carrying the word-aligned address and the store data, and gives no load response.
- R4: A store that hits updates the cached word, so a later load of that word hits and returns the new value.
- R5: A store that misses allocates nothing: a later load to that address misses and fetches the line from the next level.
- R6: A load that hits a word whose stored parity does not match its data is handled as a miss. It issues one line read, refills the line and returns the fetched word, with no fault output.
- R7: `err_count` resets to zero, rises by one for each parity-triggered refill and holds at its all-ones value without wrapping.
- R8: A processor access never produces more than one next-level request, and a pending request holds its address and direction until `mem_ack`.
- R9: After reset `cpu_ready` is high, `mem_req`, `cpu_rsp_valid` and `err_count` are zero, and every line is invalid, so the first load to any address misses.
- R10: `cpu_ready` is low from the cycle after a request is accepted until the access finishes, including the whole time a next-level request is outstanding.
- R11: Each data byte is stored with a parity bit that makes the nine bits even, generated on every fill and on every store hit. When `par_inject` is high with an accepted request, the parity bit of the lowest byte of the addressed word is inverted as that word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| par_inject | input | 1 | Invert one parity bit on the line write of this access |
| cpu_ready | output | 1 | Block idle and able to accept a request |
| cpu_rsp_valid | output | 1 | One-cycle load response strobe |
| cpu_rdata | output | 32 | Load data, valid with `cpu_rsp_valid` |
| mem_req | output | 1 | Next-level request, held until `mem_ack` |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | 32 | Next-level byte address |
| mem_wdata | output | 32 | Write-through data |
| mem_ack | input | 1 | Next-level completion; read data valid in the same cycle |
| mem_rline | input | 128 | Line data returned by the next level |
| err_count | output | 8 | Saturating count of parity-triggered refills |

## Verification
Two functions meet on a single clock edge: the refill acknowledgement that repairs a corrupted line also delivers the load response and bumps the error counter, and it can do so just as the counter reaches its ceiling. The bench reaches this by injecting parity faults on fills and store hits, then reading the poisoned words again. It uses a narrowed counter so that saturation arrives after a few events, and it mixes these faults into random traffic over a small set of conflicting tags. For every access, a bench reference model predicts the returned word, the number and kind of next-level requests, and the counter value, and compares each with the ports once the block reports ready again.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LOOK  = 2'd1,
    S_FETCH = 2'd2,
    S_WRITE = 2'd3
  } wtc_state_e;

  // even parity: the stored bit makes the nine bits hold an even number of ones
  function automatic logic even_bit(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/wtc_par_gen.sv
module wtc_par_gen #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0] data,
  output logic [BYTES-1:0]   par
);
  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    assign par[i] = wtc_pkg::even_bit(data[i*8 +: 8]);
  end
endmodule

// File: rtl/wtc_sat_cnt.sv
module wtc_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/wtc_array.sv
module wtc_array #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int PAR_W  = LINE_W / 8,
  localparam int WB     = WORD_W / 8,
  localparam int WPL    = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WPL)
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  output logic [PAR_W-1:0]  rd_par,
  // whole-line fill
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [PAR_W-1:0]  fill_par,
  // single-word update on store hit
  input  logic              word_en,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic [WORD_W-1:0] word_data,
  input  logic [WB-1:0]     word_par
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];
  logic [PAR_W-1:0]  par_q  [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_line;
      par_q[fill_idx]  <= fill_par;
    end else if (word_en) begin
      data_q[word_idx][word_sel*WORD_W +: WORD_W] <= word_data;
      par_q[word_idx][word_sel*WB +: WB]          <= word_par;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];
  assign rd_par   = par_q[rd_idx];
endmodule

// File: rtl/wt_l1_cache.sv
module wt_l1_cache #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  parameter int WORD_W     = 32,
  parameter int ERR_CNT_W  = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int PAR_W  = LINE_BYTES,
  localparam int WB     = WORD_W / 8,
  localparam int BOFF_W = $clog2(WB),
  localparam int WPL    = LINE_BYTES / WB,
  localparam int WSEL_W = $clog2(WPL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [WORD_W-1:0]    cpu_wdata,
  input  logic                 par_inject,
  output logic                 cpu_ready,
  output logic                 cpu_rsp_valid,
  output logic [WORD_W-1:0]    cpu_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic                 mem_ack,
  input  logic [LINE_W-1:0]    mem_rline,
  output logic [ERR_CNT_W-1:0] err_count
);
  import wtc_pkg::*;

  // address field arithmetic
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] f_wsel(input logic [ADDR_W-1:0] a);
    return a[BOFF_W +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction
  function automatic logic [ADDR_W-1:0] f_word_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
  endfunction

  wtc_state_e          state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                inj_q;
  logic                perr_q;
  logic                rsp_q;
  logic [WORD_W-1:0]   rdata_q;

  logic                rd_valid;
  logic [TAG_W-1:0]    rd_tag;
  logic [LINE_W-1:0]   rd_line;
  logic [PAR_W-1:0]    rd_par;

  logic [WSEL_W-1:0]   wsel;
  logic [WORD_W-1:0]   rd_word;
  logic [WB-1:0]       rd_word_par;
  logic [WB-1:0]       rd_word_calc;
  logic [WB-1:0]       st_par;
  logic [PAR_W-1:0]    fill_par_calc;
  logic [PAR_W-1:0]    fill_par;
  logic [WB-1:0]       word_par;
  logic [WORD_W-1:0]   fill_word;

  // named internal events, observed by the bound checker
  logic                hit;
  logic                perr;
  logic                st_hit_wr;
  logic                perr_evt;
  logic                fill_en;
  logic                err_inc;

  assign wsel         = f_wsel(addr_q);
  assign rd_word      = rd_line[wsel*WORD_W +: WORD_W];
  assign rd_word_par  = rd_par[wsel*WB +: WB];
  assign fill_word    = mem_rline[wsel*WORD_W +: WORD_W];

  wtc_par_gen #(.BYTES(WB)) u_chk_par (
    .data (rd_word),
    .par  (rd_word_calc)
  );

  wtc_par_gen #(.BYTES(WB)) u_st_par (
    .data (wdata_q),
    .par  (st_par)
  );

  wtc_par_gen #(.BYTES(PAR_W)) u_fill_par (
    .data (mem_rline),
    .par  (fill_par_calc)
  );

  assign hit       = rd_valid && (rd_tag == f_tag(addr_q));
  assign perr      = |(rd_word_calc ^ rd_word_par);
  assign st_hit_wr = (state_q == S_LOOK) && we_q && hit;
  assign perr_evt  = (state_q == S_LOOK) && !we_q && hit && perr;
  assign fill_en   = (state_q == S_FETCH) && mem_ack;
  assign err_inc   = fill_en && perr_q;

  // fault injection lands on the lowest byte of the addressed word
  assign word_par  = st_par ^ {{(WB-1){1'b0}}, inj_q};
  assign fill_par  = fill_par_calc ^ ({{(PAR_W-1){1'b0}}, inj_q} << (wsel*WB));

  wtc_array #(
    .LINES  (LINES),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W),
    .WORD_W (WORD_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (f_idx(addr_q)),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_line   (rd_line),
    .rd_par    (rd_par),
    .fill_en   (fill_en),
    .fill_idx  (f_idx(addr_q)),
    .fill_tag  (f_tag(addr_q)),
    .fill_line (mem_rline),
    .fill_par  (fill_par),
    .word_en   (st_hit_wr),
    .word_idx  (f_idx(addr_q)),
    .word_sel  (wsel),
    .word_data (wdata_q),
    .word_par  (word_par)
  );

  wtc_sat_cnt #(.W(ERR_CNT_W)) u_err_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_inc),
    .count (err_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      inj_q   <= 1'b0;
      perr_q  <= 1'b0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cpu_req) begin
            addr_q  <= cpu_addr;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            inj_q   <= par_inject;
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (we_q) begin
            state_q <= S_WRITE;
          end else if (hit && !perr) begin
            rsp_q   <= 1'b1;
            rdata_q <= rd_word;
            state_q <= S_IDLE;
          end else begin
            perr_q  <= hit;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            rsp_q   <= 1'b1;
            rdata_q <= fill_word;
            state_q <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (mem_ack) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready     = (state_q == S_IDLE);
  assign cpu_rsp_valid = rsp_q;
  assign cpu_rdata     = rdata_q;
  assign mem_req       = (state_q == S_FETCH) || (state_q == S_WRITE);
  assign mem_we        = (state_q == S_WRITE);
  assign mem_addr      = (state_q == S_WRITE) ? f_word_base(addr_q) : f_line_base(addr_q);
  assign mem_wdata     = wdata_q;
endmodule

// File: rtl/wt_l1_cache_chk.sv
module wt_l1_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int ERR_CNT_W  = 8,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_req,
  input logic                 cpu_ready,
  input logic                 cpu_rsp_valid,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic                 mem_ack,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [ERR_CNT_W-1:0] err_count,
  input logic                 st_hit_wr,
  input logic                 perr_evt
);
  // one bit is enough: has this access already completed a request
  logic reqs_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) reqs_seen <= 1'b0;
    else if (cpu_req && cpu_ready) reqs_seen <= 1'b0;
    else if (mem_req && mem_ack) reqs_seen <= 1'b1;
  end

  assert_one_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |-> !reqs_seen);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  assert_read_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> (cpu_ready && !mem_req));

  assert_rsp_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  assert_store_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit_wr |=> (mem_req && mem_we));

  assert_perr_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> (mem_req && !mem_we));

  assert_err_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count >= $past(err_count)));
endmodule

bind wt_l1_cache wt_l1_cache_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .ERR_CNT_W  (ERR_CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req       (cpu_req),
  .cpu_ready     (cpu_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_ack       (mem_ack),
  .mem_addr      (mem_addr),
  .err_count     (err_count),
  .st_hit_wr     (st_hit_wr),
  .perr_evt      (perr_evt)
);

// File: tb/wt_l1_cache_bench.sv
`timescale 1ns/1ps
module wt_l1_cache_bench;
  localparam int ECW   = 3;
  localparam int MWORDS = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         par_inject = 1'b0;
  logic         cpu_ready;
  logic         cpu_rsp_valid;
  logic [31:0]  cpu_rdata;
  logic         mem_req;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [31:0]  mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rline = '0;
  logic [ECW-1:0] err_count;

  always #2 clk = ~clk;

  wt_l1_cache #(.ERR_CNT_W(ECW)) u_wt_l1_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .par_inject(par_inject),
    .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rline(mem_rline), .err_count(err_count)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // next-level model
  logic [31:0] memw [MWORDS];
  int          mem_cnt = 0;
  logic        last_we;
  logic [31:0] last_addr;
  logic [31:0] last_wdata;
  int          lat = 0;
  logic [127:0] line_tmp;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_ack    <= 1'b1;
        mem_cnt    <= mem_cnt + 1;
        last_we    <= mem_we;
        last_addr  <= mem_addr;
        last_wdata <= mem_wdata;
        if (mem_we) begin
          memw[mem_addr[11:2]] <= mem_wdata;
        end else begin
          for (int k = 0; k < 4; k++) line_tmp[k*32 +: 32] = memw[{mem_addr[11:4], 2'(k)}];
          mem_rline <= line_tmp;
        end
        lat <= int'($urandom % 4);
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // reference cache model
  bit          mv [64];
  logic [21:0] mt [64];
  logic [31:0] md [64][4];
  bit [3:0]    mp [64];
  int          err_exp = 0;

  function automatic int sat_inc(input int v);
    return (v >= (1 << ECW) - 1) ? v : v + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] addr,
                        input logic [31:0] wdata, input bit inj);
    logic [5:0]  idx = addr[9:4];
    logic [1:0]  w = addr[3:2];
    logic [21:0] tag = addr[31:10];
    bit          hit = mv[idx] && (mt[idx] == tag);
    bit          pois = mp[idx][w];
    string       rq;
    int          c0;
    int          exp_reqs;
    logic [31:0] exp_data;
    if (we) rq = hit ? "R4" : "R5";
    else if (!hit) rq = "R2";
    else if (pois) rq = "R6";
    else rq = "R1";
    exp_reqs = (!we && hit && !pois) ? 0 : 1;
    exp_data = (!we && hit && !pois) ? md[idx][w] : memw[addr[11:2]];

    @(negedge clk);
    c0 = mem_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata; par_inject = inj;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0; par_inject = 1'b0;
    chk(!cpu_ready, "R10", "ready after accept", 32'(cpu_ready), 32'd0);
    while (!cpu_ready) @(negedge clk);

    chk(cpu_rsp_valid == !we, rq, "response strobe", 32'(cpu_rsp_valid), 32'(!we));
    if (!we) chk(cpu_rdata == exp_data, rq, "load data", cpu_rdata, exp_data);
    chk(mem_cnt - c0 == exp_reqs, "R8", "request count", 32'(mem_cnt - c0), 32'(exp_reqs));
    if (we) begin
      chk(last_we == 1'b1 && last_addr == {addr[31:2], 2'b00} && last_wdata == wdata,
          "R3", "write-through addr", last_addr, {addr[31:2], 2'b00});
      if (hit) begin md[idx][w] = wdata; mp[idx][w] = inj; end
    end else if (exp_reqs == 1) begin
      chk(last_we == 1'b0 && last_addr == {addr[31:4], 4'h0}, rq, "line read addr",
          last_addr, {addr[31:4], 4'h0});
      for (int k = 0; k < 4; k++) md[idx][k] = memw[{addr[11:4], 2'(k)}];
      mv[idx] = 1'b1; mt[idx] = tag; mp[idx] = '0; mp[idx][w] = inj;
      if (hit && pois) err_exp = sat_inc(err_exp);
    end
    chk(int'(err_count) == err_exp, "R7", "error count", 32'(err_count), 32'(err_exp));
  endtask

  function automatic logic [31:0] mk_addr(input int t, input int i, input int w);
    return {20'h0, 2'(t), 6'(i), 2'(w), 2'b00};
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < MWORDS; i++) memw[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    for (int i = 0; i < 64; i++) begin mv[i] = 1'b0; mp[i] = '0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready, "R9", "ready after reset", 32'(cpu_ready), 32'd1);
    chk(!mem_req && !cpu_rsp_valid, "R9", "idle outputs", 32'(mem_req), 32'd0);
    chk(err_count == '0, "R9", "counter after reset", 32'(err_count), 32'd0);

    // R9/R2 cold miss, then R1 hit
    access(1'b0, mk_addr(0, 3, 1), '0, 1'b0);
    access(1'b0, mk_addr(0, 3, 2), '0, 1'b0);
    // R3/R4 store hit then reload
    access(1'b1, mk_addr(0, 3, 2), 32'hCAFE_0001, 1'b0);
    access(1'b0, mk_addr(0, 3, 2), '0, 1'b0);
    // R5 store miss does not allocate
    access(1'b1, mk_addr(1, 9, 0), 32'hBEEF_0002, 1'b0);
    access(1'b0, mk_addr(1, 9, 0), '0, 1'b0);
    // R6/R11 poisoned fill, detection, clean afterwards
    access(1'b0, mk_addr(2, 12, 3), '0, 1'b1);
    access(1'b0, mk_addr(2, 12, 3), '0, 1'b0);
    access(1'b0, mk_addr(2, 12, 3), '0, 1'b0);
    // R11 poison written by a store hit, neighbour word still clean
    access(1'b1, mk_addr(2, 12, 1), 32'h1234_5678, 1'b1);
    access(1'b0, mk_addr(2, 12, 0), '0, 1'b0);
    access(1'b0, mk_addr(2, 12, 1), '0, 1'b0);
    // R7 drive the counter into saturation
    for (int n = 0; n < 9; n++) begin
      access(1'b0, mk_addr(3, 20 + n, n % 4), '0, 1'b1);
      access(1'b0, mk_addr(3, 20 + n, n % 4), '0, 1'b0);
    end
    chk(int'(err_count) == 7, "R7", "saturated value", 32'(err_count), 32'd7);

    // constrained random traffic
    for (int n = 0; n < 800; n++) begin
      bit st = ($urandom % 3) == 0;
      bit ij = ($urandom % 8) == 0;
      access(st, mk_addr(int'($urandom % 4), int'($urandom % 8), int'($urandom % 4)),
             $urandom, ij);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule